// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block converts a 32-bit virtual address into a physical address by reading two dependent entries from translation tables that live in ordinary memory. A base register holds the upper bits of the first-level table's physical address. The first-level entry points to a second-level table, and the second-level entry supplies the physical frame number and the page's access permission. The page offset passes through unchanged. Pages are 4 KB: VA[31:20] selects one of 4096 first-level entries, VA[19:12] selects one of 256 second-level entries, and every entry is 4 bytes.

The CPU side presents one request at a time, marked user or privileged and read or write. The block issues one memory read, waits for that read's data-valid strobe, and only then issues the next read. It finishes with a one-cycle response that carries either the physical address or a fault code. Reloading the base register switches the block to a different set of tables, for example on a process switch. Nothing prevents several virtual pages from pointing at the same frame.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `mem_req_o` is 0, `rsp_valid_o` is 0, and the base register is 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. On the next cycle `mem_req_o` is 1 with address {base[17:0], VA[31:20], 2'b00}. `req_ready_o` stays 0 until the response cycle has passed.
- R3: Only one read is outstanding at a time. While `mem_req_o` is 1 and `mem_rvalid_i` is 0, the read request and its address hold steady.
- R4: If the first-level entry is valid (bits [1:0] not 00), the second read goes to {L1[31:10], VA[19:12], 2'b00}.
- R5: If the second-level entry is valid and the access is allowed, `rsp_valid_o` is 1 for exactly one cycle. That cycle follows the edge that took the second read's data. In it, `rsp_pa_o` = {L2[31:12], VA[11:0]} and `rsp_fault_o` = 00.
- R6: A first-level entry with bits [1:0] = 00 ends the walk with `rsp_fault_o` = 01 (translation fault) and `rsp_pa_o` = 0, and no second read is issued.
- R7: A second-level entry with bits [1:0] = 00 ends the walk with `rsp_fault_o` = 01 and `rsp_pa_o` = 0.
- R8: Second-level bits [5:4] give the permission. 00 permits nothing. 01 permits privileged accesses only. 10 permits any privileged access and user reads. 11 permits everything. A disallowed access returns `rsp_fault_o` = 10 (permission fault) with `rsp_pa_o` = 0. Code 11 never occurs.
- R9: A pulse on `ttb_load_i` writes `ttb_data_i` into the base register. A load in the same cycle that a request is accepted does not affect that request's walk; it applies only to later walks.
- R10: Two virtual pages whose second-level entries name the same frame both translate to that frame, each with its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_load_i | input | 1 | Write strobe for the table base register |
| ttb_data_i | input | 18 | New table base, physical address bits [31:14] |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address |
| req_user_i | input | 1 | 1 = user mode access, 0 = privileged |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| mem_req_o | output | 1 | Table read request, held until its data returns |
| mem_addr_o | output | 32 | Physical address of the table entry being read |
| mem_rvalid_i | input | 1 | Read data valid for the current request |
| mem_rdata_i | input | 32 | Table entry read from memory |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | 32 | Translated physical address (0 on fault) |
| rsp_fault_o | output | 2 | 00 ok, 01 translation fault, 10 permission fault |

## Verification
The checker assumes that `mem_rvalid_i` is asserted only while `mem_req_o` is high and at most once per issued read. It also assumes that `req_valid_i` is considered only while the walker is idle. The bench memory model keeps to this: it counts a per-walk latency of zero to three cycles from the moment a read appears, returns exactly one strobe, then drops it before counting again for the next read. The driver raises a request only after it has seen `req_ready_o` high, and it holds the request for exactly one edge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_LSB   = 2;  // 4-byte table entries
  localparam int PERM_LSB  = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_L1, ST_L2, ST_DONE, ST_FAULT} walk_st_e;
  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_XLAT = 2'b01, FLT_PERM = 2'b10} fault_e;
  typedef enum logic [1:0] {PERM_NONE = 2'b00, PERM_PRIV = 2'b01,
                            PERM_URO = 2'b10, PERM_FULL = 2'b11} perm_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int L2_IDX_W = 8,
  localparam int L1_IDX_W  = ADDR_W - PAGE_W - L2_IDX_W,
  localparam int TBL_ALIGN = L1_IDX_W + ptw_pkg::ENT_LSB,
  localparam int L2B_LSB   = L2_IDX_W + ptw_pkg::ENT_LSB
) (
  input  logic [ADDR_W-TBL_ALIGN-1:0] base_i,
  input  logic [L1_IDX_W-1:0]         l1_idx_i,
  input  logic [ADDR_W-L2B_LSB-1:0]   l2_base_i,
  input  logic [L2_IDX_W-1:0]         l2_idx_i,
  input  logic [ADDR_W-PAGE_W-1:0]    frame_i,
  input  logic [PAGE_W-1:0]           offset_i,
  output logic [ADDR_W-1:0]           l1_addr_o,
  output logic [ADDR_W-1:0]           l2_addr_o,
  output logic [ADDR_W-1:0]           pa_o
);
  localparam logic [ptw_pkg::ENT_LSB-1:0] ENT_PAD = '0;

  assign l1_addr_o = {base_i, l1_idx_i, ENT_PAD};
  assign l2_addr_o = {l2_base_i, l2_idx_i, ENT_PAD};
  assign pa_o      = {frame_i, offset_i};
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic [1:0] perm_i,
  input  logic       user_i,
  input  logic       write_i,
  output logic       ok_o
);
  always_comb begin
    unique case (perm_e'(perm_i))
      PERM_NONE: ok_o = 1'b0;
      PERM_PRIV: ok_o = !user_i;
      PERM_URO:  ok_o = !(user_i && write_i);
      default:   ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_fire_i,
  input  logic     rvalid_i,
  input  logic     entry_ok_i,
  input  logic     perm_ok_i,
  output walk_st_e st_o
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_fire_i) st_d = ST_L1;
      ST_L1:   if (rvalid_i) st_d = entry_ok_i ? ST_L2 : ST_FAULT;
      ST_L2:   if (rvalid_i) st_d = (entry_ok_i && perm_ok_i) ? ST_DONE : ST_FAULT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int L2_IDX_W = 8,
  localparam int L1_IDX_W  = ADDR_W - PAGE_W - L2_IDX_W,
  localparam int TBL_ALIGN = L1_IDX_W + ENT_LSB,
  localparam int BASE_W    = ADDR_W - TBL_ALIGN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ttb_load_i,
  input  logic [BASE_W-1:0] ttb_data_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic              req_user_i,
  input  logic              req_write_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_pa_o,
  output logic [1:0]        rsp_fault_o
);
  localparam int L2B_LSB = L2_IDX_W + ENT_LSB;
  localparam int VPN_LSB = PAGE_W + L2_IDX_W;

  walk_st_e          st;
  logic [BASE_W-1:0] base_q;
  logic [VPN_LSB-1:0] va_lo_q;
  logic              user_q, write_q;
  logic [ADDR_W-1:0] addr_q, pa_q;
  fault_e            fault_q;
  logic [ADDR_W-1:0] l1_addr, l2_addr, pa_calc;
  logic              req_fire, entry_ok, perm_ok;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata_i;
  assign req_fire     = req_valid_i && (st == ST_IDLE);
  assign entry_ok     = mem_rdata_i[ENT_LSB-1:0] != '0;

  ptw_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_fire_i (req_fire),
    .rvalid_i   (mem_rvalid_i),
    .entry_ok_i (entry_ok),
    .perm_ok_i  (perm_ok),
    .st_o       (st)
  );

  ptw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .L2_IDX_W(L2_IDX_W)) u_addr (
    .base_i    (base_q),
    .l1_idx_i  (req_va_i[ADDR_W-1:VPN_LSB]),
    .l2_base_i (mem_rdata_i[ADDR_W-1:L2B_LSB]),
    .l2_idx_i  (va_lo_q[VPN_LSB-1:PAGE_W]),
    .frame_i   (mem_rdata_i[ADDR_W-1:PAGE_W]),
    .offset_i  (va_lo_q[PAGE_W-1:0]),
    .l1_addr_o (l1_addr),
    .l2_addr_o (l2_addr),
    .pa_o      (pa_calc)
  );

  ptw_perm_chk u_perm (
    .perm_i  (mem_rdata_i[PERM_LSB+1:PERM_LSB]),
    .user_i  (user_q),
    .write_i (write_q),
    .ok_o    (perm_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (ttb_load_i) base_q <= ttb_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_lo_q <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else if (req_fire) begin
      va_lo_q <= req_va_i[VPN_LSB-1:0];
      user_q  <= req_user_i;
      write_q <= req_write_i;
      addr_q  <= l1_addr;  // base as of this edge; a same-cycle load lands later
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else if (mem_rvalid_i && st == ST_L1) begin
      if (entry_ok) addr_q  <= l2_addr;
      else          fault_q <= FLT_XLAT;
    end else if (mem_rvalid_i && st == ST_L2) begin
      if (!entry_ok)     fault_q <= FLT_XLAT;
      else if (!perm_ok) fault_q <= FLT_PERM;
      else               pa_q    <= pa_calc;
    end
  end

  assign req_ready_o = (st == ST_IDLE);
  assign mem_req_o   = (st == ST_L1) || (st == ST_L2);
  assign mem_addr_o  = addr_q;
  assign rsp_valid_o = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [1:0]        entry_tag_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_pa_o,
  input logic [1:0]        rsp_fault_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);  // R1

  AST_ACCEPT_ISSUES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o && !req_ready_o);  // R2

  AST_READ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));  // R3

  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);  // R5

  AST_L1_INVALID_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && entry_tag_i == 2'b00 |=> !mem_req_o && rsp_valid_o);  // R6

  AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'b00 |-> rsp_pa_o == '0);  // R7

  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o != 2'b11);  // R8
endmodule

bind pt_walker ptw_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .entry_tag_i  (mem_rdata_i[1:0]),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_pa_o     (rsp_pa_o),
  .rsp_fault_o  (rsp_fault_o)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ttb_load_i = 1'b0;
  logic [17:0] ttb_data_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic        req_user_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_pa_o;
  logic [1:0]  rsp_fault_o;

  always #10 clk_i = ~clk_i;

  pt_walker dut_i (.*);

  typedef struct {
    string       tag;
    logic [31:0] pa;
    logic [1:0]  flt;
    int          nrd;
    logic [31:0] a1;
    logic [31:0] a2;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] seen_q[$];
  logic [31:0] mem [logic [31:0]];
  logic [17:0] base_model = '0;
  int          lat = 0;
  int          wcnt = 0;
  int          n_run = 0;
  int          n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input bit user, input bit wr,
                                 input logic [17:0] base, input string tag);
    exp_t e;
    logic [31:0] e1, e2;
    bit ok;
    e.tag = tag; e.pa = '0; e.flt = 2'b00; e.a2 = '0;
    e.a1 = {base, va[31:20], 2'b00};
    e1 = rd(e.a1);
    e.nrd = 1;
    if (e1[1:0] == 2'b00) begin e.flt = 2'b01; return e; end
    e.a2 = {e1[31:10], va[19:12], 2'b00};
    e2 = rd(e.a2);
    e.nrd = 2;
    if (e2[1:0] == 2'b00) begin e.flt = 2'b01; return e; end
    case (e2[5:4])
      2'b00:   ok = 1'b0;
      2'b01:   ok = !user;
      2'b10:   ok = !(user && wr);
      default: ok = 1'b1;
    endcase
    if (!ok) e.flt = 2'b10;
    else     e.pa = {e2[31:12], va[11:0]};
    return e;
  endfunction

  // memory model: one strobe per read after lat cycles
  always @(negedge clk_i) begin
    if (mem_rvalid_i) begin
      mem_rvalid_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd(mem_addr_o);
        seen_q.push_back(mem_addr_o);
      end else wcnt++;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected response", {30'd0, rsp_fault_o}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(rsp_fault_o == e.flt, {e.tag, " fault"}, {30'd0, rsp_fault_o}, {30'd0, e.flt});
        chk(rsp_pa_o == e.pa, {e.tag, " pa"}, rsp_pa_o, e.pa);
        chk(seen_q.size() == e.nrd, {e.tag, " R6 read count"}, seen_q.size(), e.nrd);
        if (seen_q.size() >= 1) chk(seen_q[0] == e.a1, {e.tag, " R2 L1 addr"}, seen_q[0], e.a1);
        if (seen_q.size() >= 2 && e.nrd == 2)
          chk(seen_q[1] == e.a2, {e.tag, " R4 L2 addr"}, seen_q[1], e.a2);
      end
      seen_q.delete();
    end
  end

  task automatic walk(input logic [31:0] va, input bit user, input bit wr, input int l,
                      input string tag, input bit do_load = 0, input logic [17:0] nb = '0);
    do @(negedge clk_i); while (!req_ready_o);
    lat = l;
    exp_q.push_back(model(va, user, wr, base_model, tag));
    req_valid_i = 1'b1; req_va_i = va; req_user_i = user; req_write_i = wr;
    if (do_load) begin ttb_load_i = 1'b1; ttb_data_i = nb; end
    @(negedge clk_i);
    req_valid_i = 1'b0; ttb_load_i = 1'b0;
    if (do_load) base_model = nb;
    chk(mem_req_o && !req_ready_o, {tag, " R2 busy after accept"}, {mem_req_o, req_ready_o}, 32'h2);
  endtask

  task automatic load_base(input logic [17:0] nb);
    @(negedge clk_i);
    ttb_load_i = 1'b1; ttb_data_i = nb;
    @(negedge clk_i);
    ttb_load_i = 1'b0;
    base_model = nb;
  endtask

  localparam logic [31:0] TBL_A = 32'h0010_0000;
  localparam logic [31:0] TBL_B = 32'h0010_4000;

  initial begin
    // table A: VA[31:20]=0x004 -> L2 at 0x00200000, 0x005 -> 0x00200400
    mem[TBL_A + 32'h10] = 32'h0020_0000 | 32'h1;
    mem[TBL_A + 32'h14] = 32'h0020_0400 | 32'h1;
    mem[32'h0020_0004] = 32'h3000_0000 | (32'h3 << 4) | 32'h2; // full
    mem[32'h0020_0008] = 32'h3000_1000 | (32'h0 << 4) | 32'h2; // none
    mem[32'h0020_000C] = 32'h3000_2000 | (32'h1 << 4) | 32'h2; // priv
    mem[32'h0020_0010] = 32'h3000_3000 | (32'h2 << 4) | 32'h2; // user ro
    mem[32'h0020_0014] = 32'h3000_4000 | (32'h3 << 4);         // invalid
    mem[32'h0020_0400] = 32'h3000_0000 | (32'h3 << 4) | 32'h1; // alias of page 1
    // table B: 0x004 -> L2 at 0x00200800
    mem[TBL_B + 32'h10] = 32'h0020_0800 | 32'h3;
    mem[32'h0020_0804] = 32'h4567_8000 | (32'h3 << 4) | 32'h1;

    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1 reset outputs",
        {req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);
    rst_ni = 1'b1;
    // base is 0 after reset: L1 read goes to {0, idx, 00}
    walk(32'h0040_1234, 0, 0, 0, "R1 R6 base zero unmapped");
    load_base(TBL_A[31:14]);
    walk(32'h0040_1234, 0, 0, 1, "R5 priv read full");
    walk(32'h0040_1ABC, 1, 1, 3, "R5 R3 user write full");
    walk(32'h0040_2000, 0, 0, 0, "R8 none priv read");
    walk(32'h0040_3010, 1, 0, 2, "R8 priv-only user read");
    walk(32'h0040_3010, 0, 1, 0, "R8 priv-only priv write");
    walk(32'h0040_4FFF, 1, 0, 1, "R8 user-ro user read");
    walk(32'h0040_4FFF, 1, 1, 0, "R8 user-ro user write");
    walk(32'h0040_4004, 0, 1, 2, "R8 user-ro priv write");
    walk(32'h0060_0000, 0, 0, 3, "R6 L1 invalid");
    walk(32'h0040_5000, 0, 0, 1, "R7 L2 invalid");
    walk(32'h0050_0ABC, 1, 1, 0, "R10 alias page");
    // load with accept: this walk still uses table A
    walk(32'h0040_1555, 0, 0, 1, "R9 same-cycle load", 1, TBL_B[31:14]);
    walk(32'h0040_1555, 1, 1, 2, "R9 after load table B");
    load_base(TBL_A[31:14]);
    walk(32'h0040_1777, 0, 0, 0, "R9 switch back");
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o, "R5 idle at end", {req_ready_o, rsp_valid_o}, 32'h2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL R3 watchdog act=hung exp=complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule